// File: doc/BRIEF.md
# SDRAM Bank Activation Tracker

This block watches the registered command stream of a four-bank double-data-rate SDRAM and keeps a model of each bank: whether a row is open and which row it is. It sees each command once, on the rising clock edge, and decides whether the command is legal given the bank state and any burst in progress. Legal commands update the model. Illegal ones leave it untouched and raise a one-cycle flag.

A legal READ or WRITE starts a burst. Two data words move per clock, so a burst of N locations lasts N/2 cycles. For each of those cycles the block reports the column of the first word of the pair. If the access asked for auto precharge, the bank closes on its own when the burst ends. The banks are tracked independently, so one bank can be activated while another is bursting.

Each bank is a two-state machine, BK_IDLE and BK_ACTIVE:
- BK_IDLE goes to BK_ACTIVE on a legal ACTIVE.
- BK_ACTIVE goes to BK_IDLE on a legal PRECHARGE aimed at that bank, on a PRECHARGE to all banks, or on an auto-precharge close.

The burst sequencer is a three-state machine:
- SQ_IDLE goes to SQ_BEAT when the burst has two or more beats.
- SQ_IDLE goes to SQ_FINAL when the burst has a single beat.
- SQ_BEAT stays in SQ_BEAT while more than one further beat remains.
- SQ_BEAT goes to SQ_FINAL when exactly one beat remains.
- SQ_FINAL returns to SQ_IDLE and issues the auto-precharge close if one was requested.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset, and whenever reset is asserted, all banks are closed, `burst_active_o` and `illegal_o` are 0, and `burst_col_o` is 0.
- R2: Command codes on `cmd_i` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE and 4 PRECHARGE; codes 5 to 7 act as NOP. An ACTIVE to a closed bank `ba_i` opens it from the next cycle. The row `addr_i[ROW_W-1:0]` appears in that bank's slice of `open_row_o`, where bank b occupies bits [b*ROW_W +: ROW_W].
- R3: An ACTIVE to a bank that is already open is illegal, and the bank's open flag and stored row stay unchanged.
- R4: A READ or WRITE to a closed bank is illegal, and no burst starts.
- R5: A legal READ or WRITE makes `burst_active_o` high from the next cycle for N/2 cycles. N comes from `bl_code_i`: 0 gives 2, 1 gives 4, and 2 or 3 give 8.
- R6: During a burst, `burst_col_o` starts at `addr_i[COL_W-1:0]` and advances by 2 each cycle. It wraps modulo N within the N-aligned block, so the bits above the block stay fixed. It reads 0 when no burst is active.
- R7: If `addr_i[10]` was 1 on the READ or WRITE, the bank closes on the same edge that ends the burst. If that bit was 0, the bank stays open.
- R8: A PRECHARGE with `addr_i[10]`=0 closes only bank `ba_i`. With `addr_i[10]`=1 it closes all banks. A PRECHARGE to a bank that is already closed is legal and has no effect.
- R9: A READ or WRITE while a burst is active is illegal and is ignored; the running burst continues unchanged.
- R10: While a burst is active, a PRECHARGE aimed at the bursting bank, or a PRECHARGE to all banks, is illegal and is ignored.
- R11: An ACTIVE to a closed bank is accepted while another bank is bursting.
- R12: `illegal_o` is high in the cycle after each illegal command, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code |
| ba_i | input | 2 | Bank select |
| addr_i | input | ROW_W (13) | Row on ACTIVE; column and auto-precharge bit on READ/WRITE; all-banks bit on PRECHARGE |
| bl_code_i | input | 2 | Burst length code |
| bank_open_o | output | 4 | One open flag per bank |
| open_row_o | output | 4*ROW_W | Stored row of each bank |
| burst_active_o | output | 1 | High while a burst occupies the data path |
| burst_col_o | output | COL_W (10) | Column of the current word pair |
| illegal_o | output | 1 | One-cycle flag for an illegal command |

## Verification
The assertions assume that `bl_code_i` holds steady while a READ or WRITE is being issued. They also assume that the command inputs settle before each rising edge. The bench drives every input at the falling edge and samples the outputs at the next falling edge, so each command is seen exactly once. Illegal commands are issued on purpose to exercise the rejection paths. The stimulus never depends on timing rules outside the block, such as the delay from activate to access, because the block does not model them.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_t;

    typedef enum logic {
        BK_IDLE,
        BK_ACTIVE
    } bank_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_BEAT,
        SQ_FINAL
    } sq_state_t;

    localparam int AP_BIT  = 10;
    localparam int MAX_BL  = 8;
    localparam int BLK_W   = $clog2(MAX_BL);
endpackage

// File: rtl/trk_cmd_decoder.sv
module trk_cmd_decoder
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic [2:0]           cmd_i,
    input  logic [BANK_W-1:0]    ba_i,
    input  logic                 a10_i,
    input  logic [NUM_BANKS-1:0] open_i,
    input  logic                 burst_active_i,
    input  logic [BANK_W-1:0]    burst_bank_i,
    output logic [NUM_BANKS-1:0] act_hit_o,
    output logic [NUM_BANKS-1:0] pre_hit_o,
    output logic                 start_o,
    output logic                 illegal_o
);
    logic is_act, is_rw, is_pre;
    logic act_ok, rw_ok, pre_ok, pre_conflict;

    always_comb begin
        is_act = (cmd_i == CMD_ACT);
        is_rw  = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
        is_pre = (cmd_i == CMD_PRE);

        act_ok       = is_act && !open_i[ba_i];
        rw_ok        = is_rw && open_i[ba_i] && !burst_active_i;
        pre_conflict = burst_active_i && (a10_i || (burst_bank_i == ba_i));
        pre_ok       = is_pre && !pre_conflict;

        start_o   = rw_ok;
        illegal_o = (is_act && !act_ok) || (is_rw && !rw_ok) || (is_pre && !pre_ok);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign act_hit_o[b] = act_ok && (ba_i == BANK_W'(b));
        assign pre_hit_o[b] = pre_ok && (a10_i || (ba_i == BANK_W'(b)));
    end
endmodule

// File: rtl/bank_state_fsm.sv
module bank_state_fsm
    import bank_trk_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_hit_i,
    input  logic             pre_hit_i,
    input  logic             close_hit_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    bank_state_t state_q, state_d;
    logic [ROW_W-1:0] row_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE:   if (act_hit_i) state_d = BK_ACTIVE;
            BK_ACTIVE: if (pre_hit_i || close_hit_i) state_d = BK_IDLE;
            default:   state_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             row_q <= '0;
        else if (state_q == BK_IDLE && act_hit_i) row_q <= row_i;
    end

    always_comb begin
        open_o = (state_q == BK_ACTIVE);
        row_o  = row_q;
    end

    // R2: a bank only opens after an accepted ACTIVE
    assert_open_from_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(act_hit_i));
    // R3: the decoder never accepts ACTIVE to an open bank
    assert_no_act_when_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |-> !act_hit_i);
    // R3: stored row holds while the bank stays open
    assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && $past(open_o)) |-> $stable(row_o));
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int COL_W     = 10,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              ap_i,
    input  logic [1:0]        bl_code_i,
    output logic              active_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [COL_W-1:0]  col_o,
    output logic              close_o
);
    sq_state_t state_q, state_d;
    logic [COL_W-1:0]  base_q;
    logic [BLK_W-1:0]  ofs_q, mask_q, rem_q;
    logic [BLK_W-1:0]  beats, mask;
    logic [BANK_W-1:0] bank_q;
    logic              ap_q;
    logic [BLK_W-1:0]  low;

    always_comb begin
        unique case (bl_code_i)
            2'd0:    begin beats = BLK_W'(1); mask = BLK_W'(1); end
            2'd1:    begin beats = BLK_W'(2); mask = BLK_W'(3); end
            default: begin beats = BLK_W'(4); mask = BLK_W'(7); end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (start_i) state_d = (beats == BLK_W'(1)) ? SQ_FINAL : SQ_BEAT;
            SQ_BEAT:  if (rem_q == BLK_W'(1)) state_d = SQ_FINAL;
            SQ_FINAL: state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ofs_q  <= '0;
            mask_q <= '0;
            rem_q  <= '0;
            bank_q <= '0;
            ap_q   <= 1'b0;
        end else if (state_q == SQ_IDLE) begin
            if (start_i) begin
                base_q <= col_i;
                ofs_q  <= '0;
                mask_q <= mask;
                rem_q  <= beats - BLK_W'(1);
                bank_q <= bank_i;
                ap_q   <= ap_i;
            end
        end else begin
            ofs_q <= ofs_q + BLK_W'(2);
            rem_q <= rem_q - BLK_W'(1);
        end
    end

    always_comb begin
        low      = (base_q[BLK_W-1:0] & ~mask_q) | ((base_q[BLK_W-1:0] + ofs_q) & mask_q);
        active_o = (state_q != SQ_IDLE);
        bank_o   = bank_q;
        col_o    = active_o ? {base_q[COL_W-1:BLK_W], low} : '0;
        close_o  = (state_q == SQ_FINAL) && ap_q;
    end

    // R9: a burst is only started when the sequencer is free
    assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (state_q == SQ_IDLE));
    // R6: the aligned block above the wrap bits stays fixed within a burst
    assert_col_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && $past(active_o)) |-> $stable(col_o[COL_W-1:BLK_W]));
    // R5: a burst follows a start
    assert_burst_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(start_i));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 cmd_i,
    input  logic [BANK_W-1:0]          ba_i,
    input  logic [ROW_W-1:0]           addr_i,
    input  logic [1:0]                 bl_code_i,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
    output logic                       burst_active_o,
    output logic [COL_W-1:0]           burst_col_o,
    output logic                       illegal_o
);
    logic [NUM_BANKS-1:0] act_hit, pre_hit, close_hit;
    logic                 start, bad_cmd, close_req;
    logic [BANK_W-1:0]    burst_bank;
    logic                 illegal_q;

    trk_cmd_decoder #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .cmd_i          (cmd_i),
        .ba_i           (ba_i),
        .a10_i          (addr_i[AP_BIT]),
        .open_i         (bank_open_o),
        .burst_active_i (burst_active_o),
        .burst_bank_i   (burst_bank),
        .act_hit_o      (act_hit),
        .pre_hit_o      (pre_hit),
        .start_o        (start),
        .illegal_o      (bad_cmd)
    );

    burst_sequencer #(.NUM_BANKS(NUM_BANKS), .COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .bank_i    (ba_i),
        .col_i     (addr_i[COL_W-1:0]),
        .ap_i      (addr_i[AP_BIT]),
        .bl_code_i (bl_code_i),
        .active_o  (burst_active_o),
        .bank_o    (burst_bank),
        .col_o     (burst_col_o),
        .close_o   (close_req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign close_hit[b] = close_req && (burst_bank == BANK_W'(b));
        bank_state_fsm #(.ROW_W(ROW_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_hit_i   (act_hit[b]),
            .pre_hit_i   (pre_hit[b]),
            .close_hit_i (close_hit[b]),
            .row_i       (addr_i),
            .open_o      (bank_open_o[b]),
            .row_o       (open_row_o[b*ROW_W +: ROW_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= bad_cmd;
    end
    assign illegal_o = illegal_q;

    // R12: the flag only follows a real command
    assert_illegal_from_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> ($past(cmd_i) != CMD_NOP));
    // R10: the bursting bank stays open for the whole burst
    assert_burst_bank_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active_o |-> bank_open_o[burst_bank]);
    // R7: auto-precharge close only hits an open bank
    assert_close_open_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        close_req |=> !bank_open_o[$past(burst_bank)]);
    // R4: no burst without an open target
    assert_start_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> bank_open_o[ba_i]);
endmodule

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  ba = 2'd0;
    logic [12:0] addr = 13'd0;
    logic [1:0]  bl = 2'd0;
    logic [3:0]  open_w;
    logic [51:0] rows;
    logic        burst;
    logic [9:0]  col;
    logic        ill;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_bank_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
        .bl_code_i(bl), .bank_open_o(open_w), .open_row_o(rows),
        .burst_active_o(burst), .burst_col_o(col), .illegal_o(ill)
    );

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;
    localparam int NV = 19;
    // {cmd, ba, addr, bl, exp_open, exp_burst, exp_col, exp_illegal}
    localparam logic [35:0] VEC [NV] = '{
        {ACT, 2'd1, 13'h0123, 2'd0, 4'b0010, 1'b0, 10'h000, 1'b0},
        {ACT, 2'd1, 13'h0055, 2'd0, 4'b0010, 1'b0, 10'h000, 1'b1},
        {RD,  2'd2, 13'h0004, 2'd0, 4'b0010, 1'b0, 10'h000, 1'b1},
        {RD,  2'd1, 13'h0005, 2'd1, 4'b0010, 1'b1, 10'h005, 1'b0},
        {NOP, 2'd0, 13'h0000, 2'd0, 4'b0010, 1'b1, 10'h007, 1'b0},
        {NOP, 2'd0, 13'h0000, 2'd0, 4'b0010, 1'b0, 10'h000, 1'b0},
        {ACT, 2'd0, 13'h01FF, 2'd0, 4'b0011, 1'b0, 10'h000, 1'b0},
        {WR,  2'd0, 13'h07F6, 2'd2, 4'b0011, 1'b1, 10'h3F6, 1'b0},
        {ACT, 2'd3, 13'h00AA, 2'd0, 4'b1011, 1'b1, 10'h3F0, 1'b0},
        {RD,  2'd1, 13'h0000, 2'd0, 4'b1011, 1'b1, 10'h3F2, 1'b1},
        {PRE, 2'd0, 13'h0000, 2'd0, 4'b1011, 1'b1, 10'h3F4, 1'b1},
        {NOP, 2'd0, 13'h0000, 2'd0, 4'b1010, 1'b0, 10'h000, 1'b0},
        {PRE, 2'd1, 13'h0000, 2'd0, 4'b1000, 1'b0, 10'h000, 1'b0},
        {ACT, 2'd2, 13'h0001, 2'd0, 4'b1100, 1'b0, 10'h000, 1'b0},
        {RD,  2'd2, 13'h00A1, 2'd0, 4'b1100, 1'b1, 10'h0A1, 1'b0},
        {NOP, 2'd0, 13'h0000, 2'd0, 4'b1100, 1'b0, 10'h000, 1'b0},
        {PRE, 2'd0, 13'h0400, 2'd0, 4'b0000, 1'b0, 10'h000, 1'b0},
        {RD,  2'd3, 13'h0000, 2'd0, 4'b0000, 1'b0, 10'h000, 1'b1},
        {NOP, 2'd0, 13'h0000, 2'd0, 4'b0000, 1'b0, 10'h000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a, input logic [1:0] l);
        cmd = c; ba = b; addr = a; bl = l;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 open", 32'(open_w), 32'h0);
        check("R1 burst", 32'(burst), 32'h0);
        check("R1 illegal", 32'(ill), 32'h0);
        check("R1 col", 32'(col), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][35:33], VEC[i][32:31], VEC[i][30:18], VEC[i][17:16]);
            check($sformatf("R2/R8 open v%0d", i), 32'(open_w), 32'(VEC[i][15:12]));
            check($sformatf("R5 burst v%0d", i), 32'(burst), 32'(VEC[i][11]));
            check($sformatf("R6 col v%0d", i), 32'(col), 32'(VEC[i][10:1]));
            check($sformatf("R12 illegal v%0d", i), 32'(ill), 32'(VEC[i][0]));
        end

        // R2 row capture
        step(ACT, 2'd3, 13'h1ABC, 2'd0);
        check("R2 open b3", 32'(open_w[3]), 32'h1);
        check("R2 row b3", 32'(rows[39 +: 13]), 32'h1ABC);
        // R3 re-activate rejected, row kept
        step(ACT, 2'd3, 13'h0001, 2'd0);
        check("R3 illegal", 32'(ill), 32'h1);
        check("R3 row kept", 32'(rows[39 +: 13]), 32'h1ABC);
        // R5/R7 code 3 gives 4 cycles, auto precharge
        step(RD, 2'd3, 13'h0402, 2'd3);
        check("R5 beat0", 32'(burst), 32'h1);
        check("R6 col0", 32'(col), 32'h002);
        step(NOP, 2'd0, 13'h0000, 2'd0);
        check("R6 col1", 32'(col), 32'h004);
        step(PRE, 2'd1, 13'h0400, 2'd0);
        check("R10 prea illegal", 32'(ill), 32'h1);
        check("R10 b3 still open", 32'(open_w[3]), 32'h1);
        check("R6 col2", 32'(col), 32'h006);
        step(NOP, 2'd0, 13'h0000, 2'd0);
        check("R5 beat3", 32'(burst), 32'h1);
        check("R6 wrap", 32'(col), 32'h000);
        check("R12 single pulse", 32'(ill), 32'h0);
        step(NOP, 2'd0, 13'h0000, 2'd0);
        check("R5 end", 32'(burst), 32'h0);
        check("R7 closed", 32'(open_w[3]), 32'h0);

        // R1 reset mid-run
        step(ACT, 2'd0, 13'h0010, 2'd0);
        check("R2 open b0", 32'(open_w[0]), 32'h1);
        rst_n = 1'b0;
        step(NOP, 2'd0, 13'h0000, 2'd0);
        check("R1 reset open", 32'(open_w), 32'h0);
        check("R1 reset burst", 32'(burst), 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule